// File: doc/BRIEF.md
# Byte-Wide SPI Master with Two-Step Completion Handshake

This block is a serial peripheral interface controller that only ever drives the bus as master. A processor reaches it through a small register port holding three registers: control, status and data. The control register chooses one of four serial clock rates, the clock polarity and phase, the interrupt enable, and holds the enable and master bits that let the block run.

A write to the data register loads the byte into a shift register and launches a transfer. Eight bits leave on MOSI, most significant first, while eight bits are sampled from MISO. On the last serial clock edge the received byte goes into a receive buffer and a completion flag is raised, which can request an interrupt. Software drops the flag with a status access followed by a data read. Until the status register has been touched, new data writes are refused. A low level on the slave-select input tells the master that another device is claiming the bus. When that happens, hardware drops the enable and master bits and abandons any byte in flight.

Top module: `spim_master`

## Requirements
- R1: After reset all registers read zero. Address 0 is control: bit 0 enable, bit 1 master, bit 2 polarity, bit 3 phase, bits 5:4 rate code, bit 6 interrupt enable, bit 7 reads zero. Address 1 is status, with the completion flag in bit 0. Address 2 reads the receive buffer on a read and loads the transmitter on a write.
- R2: Rate code r gives a serial clock period of 4<<r system clocks. The completion flag becomes visible 16*(2<<r) clock cycles after the clock edge that accepts the data write.
- R3: The serial clock rests at the polarity bit. MOSI sends the written byte most significant bit first. With phase 0, data is valid before the first edge and is sampled on odd edges. With phase 1, data changes on odd edges and is sampled on even edges.
- R4: After a transfer in any of the four modes, reading address 2 returns the byte the slave sent.
- R5: A data write starts nothing unless both the enable and master bits are set.
- R6: While slave-select is low, the enable and master bits are cleared. A transfer in progress stops, the serial clock returns to its rest level, and the completion flag stays clear.
- R7: The completion flag is set when the sixteenth serial clock edge of a transfer occurs.
- R8: The flag clears only after an access to address 1 made while it is set, followed by a read of address 2. A read of address 2 with no status access before it leaves the flag set.
- R9: While the flag is set and address 1 has not yet been accessed, data writes are ignored.
- R10: irq_o is high exactly when the flag is set, interrupt enable is 1 and imask_i is 0.
- R11: A data write made while a transfer is running is ignored and does not disturb the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (enables read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ss_ni | input | 1 | Slave-select; must stay high for master operation |
| imask_i | input | 1 | Global interrupt mask, 1 blocks irq_o |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Transfer-complete interrupt request |

## Verification
The bench uses the default parameters: an 8-bit data path and a minimum division of 4. With these values the slowest rate code needs only 256 cycles per byte, so every rate and all four polarity/phase pairs fit in a short run. The bench also has a behavioural slave that counts serial clock edges. It captures MOSI on the sampling edges and drives MISO on the other edges. This lets the bench check bit order, phase handling and exact transfer length against the requirements, without looking inside the design.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef struct packed {
    logic       irq_en;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       mst;
    logic       en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // System clocks per serial clock half period for a rate code.
  function automatic int unsigned half_cycles(input logic [1:0] rate,
                                              input int unsigned base);
    return base << rate;
  endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int unsigned HALF_BASE = 2,
  localparam int unsigned CNT_W = $clog2(HALF_BASE * 8) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_w;

  assign half_w = CNT_W'(spim_pkg::half_cycles(rate_i, HALF_BASE));
  assign tick_o = run_i && (cnt_q == half_w - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R2: the half-period counter never passes the selected limit
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < half_w));

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned EW = $clog2(2 * DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              finish_o,
  output logic [DATA_W-1:0] rx_o
);

  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DATA_W);

  logic              busy_q, sck_q, cpol_q, cpha_q;
  logic [EW-1:0]     edges_q, edge_no;
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_next;
  logic              leading, sample_now, shift_now, last_edge;

  assign edge_no    = edges_q + 1'b1;
  assign leading    = edge_no[0];
  assign sample_now = tick_i && (leading != cpha_q);
  assign shift_now  = tick_i && !sample_now && !(cpha_q && edge_no == EW'(1));
  assign last_edge  = tick_i && (edge_no == LAST_EDGE);
  assign rx_next    = sample_now ? {rx_sr[DATA_W-2:0], miso_i} : rx_sr;

  assign busy_o   = busy_q;
  assign sck_o    = busy_q ? sck_q : cpol_i;
  assign mosi_o   = tx_sr[DATA_W-1];
  assign finish_o = busy_q && last_edge;
  assign rx_o     = rx_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      edges_q <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      edges_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      sck_q   <= cpol_i;
      cpol_q  <= cpol_i;
      cpha_q  <= cpha_i;
      edges_q <= '0;
      tx_sr   <= tx_i;
      rx_sr   <= '0;
    end else if (busy_q && tick_i) begin
      sck_q   <= ~sck_q;
      edges_q <= edge_no;
      rx_sr   <= rx_next;
      if (shift_now) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (last_edge) busy_q <= 1'b0;
    end
  end

  // R7: a running transfer never counts beyond its last edge
  a_r7_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (edges_q < LAST_EDGE));

  // R3: the final edge brings the clock back to its latched rest level
  a_r3_final_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> (sck_q != cpol_q));

endmodule

// File: rtl/spim_master.sv
module spim_master #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ss_ni,
  input  logic              imask_i,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  import spim_pkg::*;

  localparam int unsigned HALF_BASE = MIN_DIV / 2;

  ctrl_t             ctrl_q;
  logic              done_q, armed_q;
  logic [DATA_W-1:0] rxbuf_q;

  logic              active, wr_data, rd_data, stat_acc, dr_open;
  logic              start, abort, busy, tick, finish;
  logic [DATA_W-1:0] rx_byte;

  assign active   = ctrl_q.en && ctrl_q.mst;
  assign wr_data  = wr_i && (addr_i == ADDR_DATA);
  assign rd_data  = rd_i && (addr_i == ADDR_DATA);
  assign stat_acc = (wr_i || rd_i) && (addr_i == ADDR_STAT);
  assign dr_open  = !done_q || armed_q;
  assign start    = wr_data && dr_open && active && !busy;
  assign abort    = busy && !active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (!ss_ni) begin
        ctrl_q.en  <= 1'b0;
        ctrl_q.mst <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (stat_acc && done_q) armed_q <= 1'b1;
      if (rd_data && armed_q) begin
        done_q  <= 1'b0;
        armed_q <= 1'b0;
      end
      if (finish) begin
        done_q  <= 1'b1;
        armed_q <= 1'b0;
        rxbuf_q <= rx_byte;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_STAT: rdata_o = {{(DATA_W-1){1'b0}}, done_q};
      ADDR_DATA: rdata_o = rxbuf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = done_q && ctrl_q.irq_en && !imask_i;

  spim_baud #(.HALF_BASE(HALF_BASE)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .rate_i (ctrl_q.rate),
    .tick_o (tick)
  );

  spim_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .abort_i  (abort),
    .tx_i     (wdata_i),
    .cpol_i   (ctrl_q.cpol),
    .cpha_i   (ctrl_q.cpha),
    .tick_i   (tick),
    .miso_i   (miso_i),
    .busy_o   (busy),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .finish_o (finish),
    .rx_o     (rx_byte)
  );

  // R6: a low slave-select leaves enable and master cleared
  a_r6_ss_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_ni |=> (!ctrl_q.en && !ctrl_q.mst));

  // R7: completion of the shift engine raises the flag
  a_r7_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> done_q);

  // R8: the flag only falls once the status access has been recorded
  a_r8_clear_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(armed_q));

  // R9: a refused data write leaves the engine idle
  a_r9_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && done_q && !armed_q && !busy) |=> !busy);

  // R10: the interrupt needs the flag and a clear mask
  a_r10_irq_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_q && !imask_i));

endmodule

// File: tb/spim_master_test.sv
`timescale 1ns/1ps
module spim_master_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ss_n = 1'b1, imask = 1'b1;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spim_master uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ss_ni(ss_n), .imask_i(imask),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .irq_o(irq)
  );

  // Behavioural slave: counts serial clock edges, drives and captures bits.
  logic       sl_on = 1'b0, sl_cpha = 1'b0;
  logic [7:0] sl_tx = 8'h00, sl_rx = 8'h00;
  int         e_cnt = 0;

  always @(sck) begin
    e_cnt = e_cnt + 1;
    if (sl_on) begin
      if ((e_cnt % 2 == 1) != sl_cpha) begin
        sl_rx = {sl_rx[6:0], mosi};
      end else if (!sl_cpha) begin
        sl_tx = {sl_tx[6:0], 1'b0};
        miso  = sl_tx[7];
      end else begin
        miso  = sl_tx[7];
        sl_tx = {sl_tx[6:0], 1'b0};
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [7:0] ctrl_word(input logic ie, input logic [1:0] r,
                                           input logic ph, input logic pl);
    return {1'b0, ie, r, ph, pl, 1'b1, 1'b1};
  endfunction

  task automatic arm_slave(input logic ph, input logic [7:0] b);
    sl_cpha = ph; sl_tx = b; sl_rx = 8'h00; miso = b[7]; e_cnt = 0; sl_on = 1'b1;
  endtask

  // Waits for the flag; returns cycles counted from the accepting edge.
  task automatic wait_done(input int limit, output int k);
    addr = 2'd1; k = 0;
    #1;
    while (rdata[0] !== 1'b1 && k < limit) begin
      @(negedge clk); k++; #1;
    end
  endtask

  // {cpol, cpha, rate, tx byte, slave byte}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 2'd1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 2'd2, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 2'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 2'd3, 8'h01, 8'h80},
    {1'b1, 1'b1, 2'd0, 8'hFF, 8'h00},
    {1'b0, 1'b1, 2'd2, 8'h96, 8'h69},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'hFF}
  };

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    addr = 2'd0; #1 chk("R1 ctrl reset", rdata, 0);
    addr = 2'd1; #1 chk("R1 status reset", rdata, 0);
    addr = 2'd2; #1 chk("R1 data reset", rdata, 0);
    chk("R1 sck reset", sck, 0);
    chk("R10 irq reset", irq, 0);

    // Vector table: all modes and rates
    for (int i = 0; i < NV; i++) begin
      logic pl, ph; logic [1:0] r; logic [7:0] tx, sb;
      {pl, ph, r, tx, sb} = VEC[i];
      bus_wr(2'd0, ctrl_word(1'b0, r, ph, pl));
      #1 chk("R3 sck rests at polarity", sck, pl);
      arm_slave(ph, sb);
      bus_wr(2'd2, tx);
      wait_done(2000, k);
      chk("R2 transfer length", k, 16 * (2 << r));
      chk("R3 mosi bits msb first", sl_rx, tx);
      chk("R3 sixteen serial edges", e_cnt, 16);
      bus_rd(2'd1, v); chk("R7 flag set", v, 1);
      bus_rd(2'd2, v); chk("R4 received byte", v, sb);
      addr = 2'd1; #1 chk("R8 flag cleared by sequence", rdata, 0);
      sl_on = 1'b0;
    end

    // R5: enable without master starts nothing
    bus_wr(2'd0, 8'h01);
    e_cnt = 0;
    bus_wr(2'd2, 8'hAA);
    repeat (100) @(negedge clk);
    chk("R5 no clock edges without master", e_cnt, 0);
    addr = 2'd1; #1 chk("R5 no flag without master", rdata, 0);

    // R9, R8, R10: blocked write and clear sequence
    bus_wr(2'd0, ctrl_word(1'b1, 2'd0, 1'b0, 1'b0));
    arm_slave(1'b0, 8'h4D);
    bus_wr(2'd2, 8'h11);
    wait_done(2000, k);
    imask = 1'b1; #1 chk("R10 irq masked", irq, 0);
    imask = 1'b0; #1 chk("R10 irq raised", irq, 1);
    e_cnt = 0;
    bus_wr(2'd2, 8'h22);
    repeat (100) @(negedge clk);
    chk("R9 write ignored while flag pending", e_cnt, 0);
    bus_rd(2'd2, v); chk("R9 buffer kept", v, 8'h4D);
    addr = 2'd1; #1 chk("R8 data read alone keeps flag", rdata, 1);
    bus_rd(2'd1, v);
    bus_rd(2'd2, v);
    addr = 2'd1; #1 chk("R8 flag cleared", rdata, 0);
    chk("R10 irq drops with flag", irq, 0);
    imask = 1'b1;

    // R11: write during a transfer is ignored
    bus_wr(2'd0, ctrl_word(1'b0, 2'd1, 1'b1, 1'b0));
    arm_slave(1'b1, 8'hE7);
    bus_wr(2'd2, 8'hA5);
    repeat (10) @(negedge clk);
    bus_wr(2'd2, 8'hFF);
    wait_done(2000, k);
    chk("R11 byte in flight undisturbed", sl_rx, 8'hA5);
    bus_rd(2'd1, v); bus_rd(2'd2, v);
    chk("R11 received byte", v, 8'hE7);

    // R6: slave-select low aborts and clears enable/master
    bus_wr(2'd0, ctrl_word(1'b0, 2'd3, 1'b0, 1'b1));
    arm_slave(1'b0, 8'h55);
    bus_wr(2'd2, 8'h33);
    repeat (40) @(negedge clk);
    ss_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 sck at rest after abort", sck, 1);
    addr = 2'd0; #1 chk("R6 enable and master cleared", rdata[1:0], 0);
    repeat (400) @(negedge clk);
    addr = 2'd1; #1 chk("R6 no flag after abort", rdata, 0);
    ss_n = 1'b1;
    sl_on = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule